// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply-Accumulate Slice

This block is a clocked arithmetic slice. It forms a 25-bit multiplicand from the low bits of the A operand, optionally summed with or subtracted from the D operand. It multiplies that value by the 18-bit B operand as signed numbers and adds the product to a second operand. The second operand is either the 48-bit C input or the slice's own registered result.

The accumulate path folds running sums into the slice. Setting the source select to C for a single cycle loads a fresh starting value, C plus the current product, without clearing the pipeline. Every stage can be built in or left out by parameter: two-deep A and B chains, D, the pre-add result, the product, C and the result. Each stage present has its own clock enable, and most also have their own synchronous reset. A flag on the result reports when it has reached or passed a power-of-two threshold.

Top module: `premac_slice`

## Requirements
- R1: With the default build (two A stages, two B stages, and D, pre-add, product, C and result stages each present), a change on `a_in` reaches `p_out` after 5 rising edges. A change on `b_in` or `d_in` takes 4 edges, and a change on `c_in` takes 2 edges.
- R2: With `pre_en`=1 the multiplicand is `d_in` + `a_in[24:0]`, or `d_in` − `a_in[24:0]` when `pre_sub`=1. With `pre_en`=0 it is `a_in[24:0]` alone. The result wraps at 25 bits, and `a_in[29:25]` never affects the result.
- R3: The multiplicand (25-bit) and `b_in` are multiplied as signed two's-complement values. The 43-bit product is sign-extended to 48 bits, including the extreme products max×max and min×min.
- R4: With `acc_sel_c`=1 the next result is product + registered C. With `acc_sel_c`=0 it is product + the current `p_out` (accumulate). A single cycle with `acc_sel_c`=1 reloads the sum.
- R5: A stage whose clock enable is low keeps its value, whatever its input does.
- R6: Synchronous resets clear only their own stage and win over that stage's enable: `rst_a` (A stage next to the multiplier), `rst_b` (B stage next to the multiplier), `rst_d`, `rst_m` (product), `rst_c` and `rst_p` (result).
- R7: The first B stage has no reset. While `rst_b` clears the second B stage, the first still captures `b_in` when `ce_b1` is high, and that value can later be moved on.
- R8: `ovf` is 1 exactly when the registered result, read unsigned, is at least 2^24 (parameter `OVF_BIT`). It is formed as a masked match of the bits at and above that position against zero.
- R9: All stages power up at zero, so `p_out` and `ovf` read 0 before any data is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| a_in | input | 30 | A operand; low 25 bits feed the multiplicand |
| b_in | input | 18 | Signed multiplier operand |
| c_in | input | 48 | Post-add operand |
| d_in | input | 25 | Signed pre-add operand |
| ce_a1 | input | 1 | Enable, first A stage |
| ce_a2 | input | 1 | Enable, A stage next to the multiplier |
| rst_a | input | 1 | Sync clear, A stage next to the multiplier |
| ce_b1 | input | 1 | Enable, first B stage |
| ce_b2 | input | 1 | Enable, B stage next to the multiplier |
| rst_b | input | 1 | Sync clear, B stage next to the multiplier |
| ce_d | input | 1 | Enable, D stage |
| rst_d | input | 1 | Sync clear, D stage |
| ce_ad | input | 1 | Enable, pre-add result stage |
| ce_c | input | 1 | Enable, C stage |
| rst_c | input | 1 | Sync clear, C stage |
| ce_m | input | 1 | Enable, product stage |
| rst_m | input | 1 | Sync clear, product stage |
| ce_p | input | 1 | Enable, result stage |
| rst_p | input | 1 | Sync clear, result stage |
| pre_en | input | 1 | 1: use the pre-adder |
| pre_sub | input | 1 | 1: pre-adder subtracts A from D |
| acc_sel_c | input | 1 | Post-add source: 1 = C, 0 = own result |
| p_out | output | 48 | Result |
| ovf | output | 1 | Result at or above 2^OVF_BIT |

## Verification
The assertions watch the result and product stages on every cycle. They check that a reset empties its stage, that a disabled result holds, and that an accumulate step adds exactly the product present. They also check the threshold flag against a plain comparison, and that the first B stage keeps loading while the stage after it is cleared. The latency of each path, the arithmetic for signed corner values and pre-adder wrap, and the reload of the accumulator from C need known operands. Only the directed scenarios show those, along with the holding of stages whose contents reach the result only later.

// File: rtl/premac_slice.sv
`timescale 1ns/1ps
module premac_slice #(
  parameter int A_W      = 30,
  parameter int B_W      = 18,
  parameter int D_W      = 25,
  parameter int P_W      = 48,
  parameter int A_STAGES = 2,
  parameter int B_STAGES = 2,
  parameter bit D_REG    = 1'b1,
  parameter bit AD_REG   = 1'b1,
  parameter bit M_REG    = 1'b1,
  parameter bit C_REG    = 1'b1,
  parameter bit P_REG    = 1'b1,
  parameter int OVF_BIT  = 24
) (
  input  logic           clk,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic [P_W-1:0] c_in,
  input  logic [D_W-1:0] d_in,
  input  logic           ce_a1,
  input  logic           ce_a2,
  input  logic           rst_a,
  input  logic           ce_b1,
  input  logic           ce_b2,
  input  logic           rst_b,
  input  logic           ce_d,
  input  logic           rst_d,
  input  logic           ce_ad,
  input  logic           ce_c,
  input  logic           rst_c,
  input  logic           ce_m,
  input  logic           rst_m,
  input  logic           ce_p,
  input  logic           rst_p,
  input  logic           pre_en,
  input  logic           pre_sub,
  input  logic           acc_sel_c,
  output logic [P_W-1:0] p_out,
  output logic           ovf
);
  localparam int PROD_W = D_W + B_W;
  localparam logic [P_W-1:0] OVF_MASK  = (P_W'(1) << OVF_BIT) - P_W'(1);
  localparam logic [P_W-1:0] OVF_LIMIT = P_W'(1) << OVF_BIT;

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  logic [A_W-1:0]    a_near;
  logic [B_W-1:0]    b_near;
  logic [D_W-1:0]    d_val;
  logic [D_W-1:0]    ad_comb, ad_val;
  logic [PROD_W-1:0] prod, m_val;
  logic [P_W-1:0]    c_val, prod_ext, p_fb, p_next;
  logic              unused_a_hi;

  generate
    if (A_STAGES == 0) begin : g_a0
      assign a_near = a_in;
    end else if (A_STAGES == 1) begin : g_a1
      logic [A_W-1:0] a_q = '0;
      always_ff @(posedge clk)
        if (rst_a) a_q <= '0;
        else if (ce_a2) a_q <= a_in;
      assign a_near = a_q;
    end else begin : g_a2
      logic [A_W-1:0] a1_q = '0, a2_q = '0;
      always_ff @(posedge clk)
        if (ce_a1) a1_q <= a_in;
      always_ff @(posedge clk)
        if (rst_a) a2_q <= '0;
        else if (ce_a2) a2_q <= a1_q;
      assign a_near = a2_q;
    end

    if (B_STAGES == 0) begin : g_b0
      assign b_near = b_in;
    end else if (B_STAGES == 1) begin : g_b1
      logic [B_W-1:0] b_q = '0;
      always_ff @(posedge clk)
        if (rst_b) b_q <= '0;
        else if (ce_b2) b_q <= b_in;
      assign b_near = b_q;
    end else begin : g_b2
      logic [B_W-1:0] b1_q = '0, b2_q = '0;
      always_ff @(posedge clk)
        if (ce_b1) b1_q <= b_in;
      always_ff @(posedge clk)
        if (rst_b) b2_q <= '0;
        else if (ce_b2) b2_q <= b1_q;
      assign b_near = b2_q;

      assert_b_first_no_reset_R7: assert property (@(posedge clk) disable iff (!started)
        (rst_b && ce_b1) |=> (b1_q == $past(b_in)));
      assert_b_near_reset_R6: assert property (@(posedge clk) disable iff (!started)
        rst_b |=> (b2_q == '0));
    end

    if (D_REG) begin : g_d1
      logic [D_W-1:0] d_q = '0;
      always_ff @(posedge clk)
        if (rst_d) d_q <= '0;
        else if (ce_d) d_q <= d_in;
      assign d_val = d_q;
    end else begin : g_d0
      assign d_val = d_in;
    end
  endgenerate

  assign unused_a_hi = ^a_near[A_W-1:D_W];

  always_comb begin
    if (!pre_en)      ad_comb = a_near[D_W-1:0];
    else if (pre_sub) ad_comb = d_val - a_near[D_W-1:0];
    else              ad_comb = d_val + a_near[D_W-1:0];
  end

  generate
    if (AD_REG) begin : g_ad1
      logic [D_W-1:0] ad_q = '0;
      always_ff @(posedge clk)
        if (ce_ad) ad_q <= ad_comb;
      assign ad_val = ad_q;
    end else begin : g_ad0
      assign ad_val = ad_comb;
    end
  endgenerate

  assign prod = PROD_W'($signed(ad_val) * $signed(b_near));

  generate
    if (M_REG) begin : g_m1
      logic [PROD_W-1:0] m_q = '0;
      always_ff @(posedge clk)
        if (rst_m) m_q <= '0;
        else if (ce_m) m_q <= prod;
      assign m_val = m_q;

      assert_m_reset_R6: assert property (@(posedge clk) disable iff (!started)
        rst_m |=> (m_q == '0));
      assert_m_hold_R5: assert property (@(posedge clk) disable iff (!started)
        (!rst_m && !ce_m) |=> $stable(m_q));
    end else begin : g_m0
      assign m_val = prod;
    end

    if (C_REG) begin : g_c1
      logic [P_W-1:0] c_q = '0;
      always_ff @(posedge clk)
        if (rst_c) c_q <= '0;
        else if (ce_c) c_q <= c_in;
      assign c_val = c_q;
    end else begin : g_c0
      assign c_val = c_in;
    end
  endgenerate

  assign prod_ext = {{(P_W-PROD_W){m_val[PROD_W-1]}}, m_val};
  assign p_next   = prod_ext + (acc_sel_c ? c_val : p_fb);

  generate
    if (P_REG) begin : g_p1
      logic [P_W-1:0] p_q = '0;
      always_ff @(posedge clk)
        if (rst_p) p_q <= '0;
        else if (ce_p) p_q <= p_next;
      assign p_fb  = p_q;
      assign p_out = p_q;

      assert_p_reset_R6: assert property (@(posedge clk) disable iff (!started)
        rst_p |=> (p_out == '0));
      assert_p_hold_R5: assert property (@(posedge clk) disable iff (!started)
        (!rst_p && !ce_p) |=> $stable(p_out));
      assert_p_accumulate_R4: assert property (@(posedge clk) disable iff (!started)
        (ce_p && !rst_p && !acc_sel_c) |=> (p_out == $past(p_out) + $past(prod_ext)));
    end else begin : g_p0
      assign p_fb  = '0;
      assign p_out = p_next;
    end
  endgenerate

  assign ovf = ~&(~p_out | OVF_MASK);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!started)
    ovf == (p_out >= OVF_LIMIT));
endmodule

// File: tb/premac_slice_bench.sv
`timescale 1ns/1ps
module premac_slice_bench;
  logic        clk = 1'b0;
  logic [29:0] a_in = '0;
  logic [17:0] b_in = '0;
  logic [47:0] c_in = '0;
  logic [24:0] d_in = '0;
  logic ce_a1 = 1, ce_a2 = 1, rst_a = 0, ce_b1 = 1, ce_b2 = 1, rst_b = 0;
  logic ce_d = 1, rst_d = 0, ce_ad = 1, ce_c = 1, rst_c = 0;
  logic ce_m = 1, rst_m = 0, ce_p = 1, rst_p = 0;
  logic pre_en = 0, pre_sub = 0, acc_sel_c = 1;
  logic [47:0] p_out;
  logic        ovf;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  premac_slice u_premac_slice (
    .clk(clk), .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
    .ce_a1(ce_a1), .ce_a2(ce_a2), .rst_a(rst_a),
    .ce_b1(ce_b1), .ce_b2(ce_b2), .rst_b(rst_b),
    .ce_d(ce_d), .rst_d(rst_d), .ce_ad(ce_ad),
    .ce_c(ce_c), .rst_c(rst_c), .ce_m(ce_m), .rst_m(rst_m),
    .ce_p(ce_p), .rst_p(rst_p),
    .pre_en(pre_en), .pre_sub(pre_sub), .acc_sel_c(acc_sel_c),
    .p_out(p_out), .ovf(ovf)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    ce_a1 = 1; ce_a2 = 1; ce_b1 = 1; ce_b2 = 1; ce_d = 1; ce_ad = 1;
    ce_c = 1; ce_m = 1; ce_p = 1;
    rst_a = 0; rst_b = 0; rst_d = 0; rst_c = 0; rst_m = 0; rst_p = 0;
    acc_sel_c = 1;
    step(8);
  endtask

  task automatic load(input logic [29:0] a, input logic [17:0] b, input logic [24:0] d,
                      input logic [47:0] c, input logic pe, input logic ps);
    a_in = a; b_in = b; d_in = d; c_in = c; pre_en = pe; pre_sub = ps;
    settle();
  endtask

  task automatic t_reset_state();
    step(1);
    check("R9 p_out at power-up", p_out, 48'd0);
    check("R9 ovf at power-up", {47'd0, ovf}, 48'd0);
  endtask

  task automatic t_preadder();
    load(30'd3, 18'd7, 25'd10, 48'd5, 1, 0);
    check("R2 pre-add D+A", p_out, 48'd96);
    load(30'd3, 18'd7, 25'd10, 48'd5, 1, 1);
    check("R2 pre-sub D-A", p_out, 48'd54);
    load(30'd3, 18'd7, 25'd10, 48'd5, 0, 0);
    check("R2 pre-adder off", p_out, 48'd26);
    load(30'h2000_0003, 18'd7, 25'd0, 48'd0, 0, 0);
    check("R2 A upper bits ignored", p_out, 48'd21);
    load(30'd1, 18'd1, 25'h0FF_FFFF, 48'd0, 1, 0);
    check("R2 25-bit wrap", p_out, 48'hFFFF_FF00_0000);
  endtask

  task automatic t_signed_product();
    load(30'h3FFF_FFFC, 18'h3FFFD, 25'd0, 48'd0, 0, 0);
    check("R3 neg x neg", p_out, 48'd12);
    load(30'd50, 18'd5, 25'h1FF_FF9C, 48'd0, 1, 0);
    check("R3 negative sign-extended", p_out, 48'hFFFF_FFFF_FF06);
    load(30'h00FF_FFFF, 18'h1FFFF, 25'd0, 48'd0, 0, 0);
    check("R3 max x max", p_out, 48'd2199006347265);
    load(30'h3F00_0000, 18'h20000, 25'd0, 48'd0, 0, 0);
    check("R3 min x min", p_out, 48'd2199023255552);
  endtask

  task automatic t_latency();
    load(30'd2, 18'd3, 25'd0, 48'd0, 1, 0);
    a_in = 30'd5;
    for (int i = 1; i <= 5; i++) begin
      step(1);
      check("R1 A path latency", p_out, (i < 5) ? 48'd6 : 48'd15);
    end
    b_in = 18'd4;
    for (int i = 1; i <= 4; i++) begin
      step(1);
      check("R1 B path latency", p_out, (i < 4) ? 48'd15 : 48'd20);
    end
    d_in = 25'd1;
    for (int i = 1; i <= 4; i++) begin
      step(1);
      check("R1 D path latency", p_out, (i < 4) ? 48'd20 : 48'd24);
    end
    c_in = 48'd100;
    for (int i = 1; i <= 2; i++) begin
      step(1);
      check("R1 C path latency", p_out, (i < 2) ? 48'd24 : 48'd124);
    end
  endtask

  task automatic t_accumulate();
    load(30'd2, 18'd3, 25'd0, 48'd0, 0, 0);
    c_in = 48'd1000;
    acc_sel_c = 0;
    for (int i = 1; i <= 3; i++) begin
      step(1);
      check("R4 accumulate", p_out, 48'(6 * (i + 1)));
    end
    acc_sel_c = 1;
    step(1);
    check("R4 reload from C", p_out, 48'd1006);
  endtask

  task automatic t_enables();
    load(30'd2, 18'd3, 25'd0, 48'd0, 0, 0);
    ce_p = 0; a_in = 30'd5;
    step(6);
    check("R5 result hold", p_out, 48'd6);
    ce_p = 1;
    step(1);
    check("R5 result release", p_out, 48'd15);
    ce_m = 0; a_in = 30'd7;
    step(6);
    check("R5 product hold", p_out, 48'd15);
    ce_m = 1;
    step(1);
    check("R5 product release edge 1", p_out, 48'd15);
    step(1);
    check("R5 product release edge 2", p_out, 48'd21);
    ce_c = 0; c_in = 48'd50;
    step(4);
    check("R5 C hold", p_out, 48'd21);
    ce_c = 1;
    step(1);
    check("R5 C release edge 1", p_out, 48'd21);
    step(1);
    check("R5 C release edge 2", p_out, 48'd71);
  endtask

  task automatic t_resets();
    load(30'd2, 18'd3, 25'd0, 48'd7, 0, 0);
    rst_p = 1;
    step(1);
    check("R6 result reset over enable", p_out, 48'd0);
    check("R6 ovf after result reset", {47'd0, ovf}, 48'd0);
    rst_p = 0;
    step(1);
    check("R6 result after reset", p_out, 48'd13);
    rst_m = 1;
    step(2);
    check("R6 product reset", p_out, 48'd7);
    rst_m = 0;
    step(2);
    rst_c = 1;
    step(1);
    check("R6 C reset edge 1", p_out, 48'd13);
    step(1);
    check("R6 C reset edge 2", p_out, 48'd6);
    rst_c = 0;
    load(30'd2, 18'd3, 25'd4, 48'd0, 1, 0);
    check("R6 D setup", p_out, 48'd18);
    rst_d = 1;
    step(4);
    check("R6 D reset", p_out, 48'd6);
    rst_d = 0;
    step(6);
    rst_a = 1;
    step(5);
    check("R6 A near-stage reset", p_out, 48'd12);
    rst_a = 0;
  endtask

  task automatic t_b_first_stage();
    load(30'd2, 18'd3, 25'd0, 48'd0, 0, 0);
    b_in = 18'd9; rst_b = 1;
    step(1);
    rst_b = 0; ce_b1 = 0; ce_b2 = 0;
    step(3);
    check("R7 near B stage cleared", p_out, 48'd0);
    b_in = 18'd1; ce_b2 = 1;
    step(1);
    ce_b2 = 0;
    step(2);
    check("R7 first B stage kept value", p_out, 48'd18);
  endtask

  task automatic t_overflow();
    load(30'd0, 18'd0, 25'd0, 48'h00_FFFFFF, 0, 0);
    check("R8 below threshold value", p_out, 48'h00_FFFFFF);
    check("R8 below threshold flag", {47'd0, ovf}, 48'd0);
    load(30'd0, 18'd0, 25'd0, 48'h100_0000, 0, 0);
    check("R8 at threshold flag", {47'd0, ovf}, 48'd1);
    load(30'd0, 18'd0, 25'd0, 48'hFFFF_FFFF_FFFF, 0, 0);
    check("R8 all ones flag", {47'd0, ovf}, 48'd1);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_preadder();
    t_signed_product();
    t_latency();
    t_accumulate();
    t_enables();
    t_resets();
    t_b_first_stage();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule